// File: doc/BRIEF.md
# Transmit Byte Statistics Counter

This block keeps a running total of the bytes a MAC transmitter has put on the wire. When a frame finishes, the transmitter raises a completion strobe with that frame's byte count. The count covers partial frames cut short by a collision. It also covers frames later truncated for being too long, which are counted at their full presented length, so the total may be larger than the bytes actually sent. Preamble, start delimiter and jam bytes are not part of the count.

In half-duplex flow-control mode, the transmitter sends preamble bytes purely to apply back-pressure. It reports them as a separate event stream. While the flow-control enable is set, these bytes are summed in a 16-bit saturating accumulator. The sum is folded into the next frame's increment, and that combined increment is capped at 65,535. The 32-bit total wraps on overflow. A host can load the total with a single-cycle write strobe and sample it with a single-cycle read strobe.

Top module: `tx_byte_tally`

## Requirements
- R1: After reset the total (`totalOut`) and the read data (`hostRdData`) are zero.
- R2: With `fcEnable` low, a cycle with `frameDone` high and `hostWrEn` low adds `frameBytes` to the total, and it is visible on `totalOut` one cycle later. Back-pressure events have no effect on this or any later increment.
- R3: With `fcEnable` high, the `bpBytes` of each `bpValid` cycle are summed, and the sum is added to the increment of the next completed frame. The sum then clears to zero, so the frame after that adds only its own bytes.
- R4: A `bpValid` event in the same cycle as `frameDone`, with `fcEnable` high, is included in that frame's increment before the cap is applied.
- R5: The increment applied for one frame (frame bytes plus back-pressure bytes) is limited to 65,535.
- R6: The back-pressure sum saturates at 65,535. Events beyond that point are lost.
- R7: The total wraps modulo 2^32 on overflow.
- R8: `hostWrEn` loads `hostWrData` into the total one cycle later. When `frameDone` is high in the same cycle, the write value wins, the frame increment is discarded, and the back-pressure sum (including any same-cycle event) is still cleared.
- R9: `hostRdEn` captures the total as it stood before that clock edge into `hostRdData`, visible one cycle later. Without `hostRdEn`, `hostRdData` holds its value.
- R10: Driving `fcEnable` low clears the back-pressure sum, so bytes gathered before that point never reach a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fcEnable | input | 1 | Half-duplex flow-control mode enable |
| frameDone | input | 1 | One-cycle strobe: a frame has left the transmitter |
| frameBytes | input | 16 | Bytes of that frame, valid with `frameDone` |
| bpValid | input | 1 | One-cycle strobe: back-pressure preamble was sent |
| bpBytes | input | 8 | Back-pressure preamble bytes, valid with `bpValid` |
| hostWrEn | input | 1 | Host write strobe for the total |
| hostWrData | input | 32 | Value loaded by a host write |
| hostRdEn | input | 1 | Host read strobe |
| hostRdData | output | 32 | Total captured by the last read |
| totalOut | output | 32 | Live byte total |

## Verification
The hardest state to reach from the ports is a saturated back-pressure sum, which takes hundreds of maximum-size events with no frame in between. The stimulus issues a long burst of 255-byte events and then a zero-byte frame. This shows both the saturated value and the lost excess in a single increment. A host write just below 2^32 puts the total near its wrap point, so that wrap can be reached in a few frames. Same-cycle collisions between frame, back-pressure and host write are forced on purpose. A reference model compares the outputs on every clock.

// File: rtl/txbs_pkg.sv
package txbs_pkg;
  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic loadHost;   // load host write value into the total
    logic addFrame;   // add the capped frame increment to the total
    logic accAdd;     // add this cycle's back-pressure bytes to the accumulator
    logic accClear;   // force the accumulator to zero
    logic mergeBp;    // include this cycle's back-pressure bytes in the frame increment
    logic capture;    // copy the total into the read register
  } txbsCtrl_t;
endpackage

// File: rtl/txbs_control.sv
module txbs_control
  import txbs_pkg::*;
(
  input  logic      fcEnable,
  input  logic      frameDone,
  input  logic      bpValid,
  input  logic      hostWrEn,
  input  logic      hostRdEn,
  output txbsCtrl_t ctrl
);
  logic bpLive;

  always_comb begin
    bpLive        = bpValid & fcEnable;
    ctrl          = '0;
    ctrl.capture  = hostRdEn;
    // A host write takes priority over a frame increment
    ctrl.loadHost = hostWrEn;
    ctrl.addFrame = frameDone & ~hostWrEn;
    // Back-pressure bytes ride on the frame completing in the same cycle
    ctrl.mergeBp  = frameDone & bpLive;
    // Otherwise they are banked for the next frame
    ctrl.accAdd   = bpLive & ~frameDone;
    // The bank empties when consumed by a frame or when the mode is off
    ctrl.accClear = frameDone | ~fcEnable;
  end
endmodule

// File: rtl/txbs_datapath.sv
module txbs_datapath
  import txbs_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 16,
  parameter int FRM_W = 16,
  parameter int BP_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  txbsCtrl_t        ctrl,
  input  logic [FRM_W-1:0] frameBytes,
  input  logic [BP_W-1:0]  bpBytes,
  input  logic [CNT_W-1:0] hostWrData,
  output logic [CNT_W-1:0] totalOut,
  output logic [CNT_W-1:0] hostRdData,
  output logic [INC_W-1:0] accVal
);
  localparam int WIDE_W = ((FRM_W > INC_W) ? FRM_W : INC_W) + 2;
  localparam logic [INC_W-1:0] CAP = {INC_W{1'b1}};

  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] rdReg;
  logic [INC_W-1:0] acc;
  logic [INC_W:0]   accSum;
  logic [INC_W-1:0] accNext;
  logic [WIDE_W-1:0] frameSum;
  logic [INC_W-1:0] inc;
  logic [CNT_W-1:0] totalNext;

  // Accumulator path: saturating add of back-pressure bytes
  always_comb begin
    accSum = {1'b0, acc} + {{(INC_W+1-BP_W){1'b0}}, bpBytes};
    if (ctrl.accClear)      accNext = '0;
    else if (ctrl.accAdd)   accNext = accSum[INC_W] ? CAP : accSum[INC_W-1:0];
    else                    accNext = acc;
  end

  // Increment path: frame bytes + banked bytes + same-cycle bytes, then cap
  always_comb begin
    frameSum = WIDE_W'(frameBytes) + WIDE_W'(acc)
             + (ctrl.mergeBp ? WIDE_W'(bpBytes) : WIDE_W'(0));
    if (frameSum > WIDE_W'(CAP)) inc = CAP;
    else                         inc = frameSum[INC_W-1:0];
  end

  always_comb begin
    if (ctrl.loadHost)      totalNext = hostWrData;
    else if (ctrl.addFrame) totalNext = total + CNT_W'(inc);
    else                    totalNext = total;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      total <= '0;
      rdReg <= '0;
      acc   <= '0;
    end else begin
      total <= totalNext;
      acc   <= accNext;
      if (ctrl.capture) rdReg <= total;
    end
  end

  assign totalOut   = total;
  assign hostRdData = rdReg;
  assign accVal     = acc;
endmodule

// File: rtl/tx_byte_tally.sv
module tx_byte_tally
  import txbs_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 16,
  parameter int FRM_W = 16,
  parameter int BP_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fcEnable,
  input  logic             frameDone,
  input  logic [FRM_W-1:0] frameBytes,
  input  logic             bpValid,
  input  logic [BP_W-1:0]  bpBytes,
  input  logic             hostWrEn,
  input  logic [CNT_W-1:0] hostWrData,
  input  logic             hostRdEn,
  output logic [CNT_W-1:0] hostRdData,
  output logic [CNT_W-1:0] totalOut
);
  txbsCtrl_t        ctrl;
  logic [INC_W-1:0] accVal;

  txbs_control ctl_i (
    .fcEnable (fcEnable),
    .frameDone(frameDone),
    .bpValid  (bpValid),
    .hostWrEn (hostWrEn),
    .hostRdEn (hostRdEn),
    .ctrl     (ctrl)
  );

  txbs_datapath #(
    .CNT_W(CNT_W), .INC_W(INC_W), .FRM_W(FRM_W), .BP_W(BP_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .frameBytes(frameBytes),
    .bpBytes   (bpBytes),
    .hostWrData(hostWrData),
    .totalOut  (totalOut),
    .hostRdData(hostRdData),
    .accVal    (accVal)
  );
endmodule

// File: rtl/txbs_checker.sv
module txbs_checker #(
  parameter int CNT_W = 32,
  parameter int INC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             fcEnable,
  input logic             frameDone,
  input logic             hostWrEn,
  input logic [CNT_W-1:0] hostWrData,
  input logic             hostRdEn,
  input logic [CNT_W-1:0] hostRdData,
  input logic [CNT_W-1:0] totalOut,
  input logic [INC_W-1:0] accVal
);
  localparam logic [INC_W-1:0] CAP = {INC_W{1'b1}};

  // R8
  host_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |=> totalOut == $past(hostWrData));

  // R5
  inc_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !hostWrEn) |=> (totalOut - $past(totalOut)) <= CNT_W'(CAP));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameDone && !hostWrEn) |=> $stable(totalOut));

  // R3
  acc_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> accVal == '0);

  // R10
  acc_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fcEnable |=> accVal == '0);

  // R6
  acc_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accVal == CAP && fcEnable && !frameDone) |=> accVal == CAP);

  // R9
  read_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRdEn |=> hostRdData == $past(totalOut));

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdEn |=> $stable(hostRdData));
endmodule

bind tx_byte_tally txbs_checker #(.CNT_W(CNT_W), .INC_W(INC_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .fcEnable  (fcEnable),
  .frameDone (frameDone),
  .hostWrEn  (hostWrEn),
  .hostWrData(hostWrData),
  .hostRdEn  (hostRdEn),
  .hostRdData(hostRdData),
  .totalOut  (totalOut),
  .accVal    (accVal)
);

// File: tb/tx_byte_tally_tb.sv
module tx_byte_tally_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fcEnable = 1'b0;
  logic        frameDone = 1'b0;
  logic [15:0] frameBytes = '0;
  logic        bpValid = 1'b0;
  logic [7:0]  bpBytes = '0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic        hostRdEn = 1'b0;
  logic [31:0] hostRdData;
  logic [31:0] totalOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Behavioural reference state
  longint mTotal = 0;
  longint mAcc = 0;
  longint mRd = 0;

  always #2.5 clk = ~clk;

  tx_byte_tally dut_i (
    .clk(clk), .rstN(rstN), .fcEnable(fcEnable), .frameDone(frameDone),
    .frameBytes(frameBytes), .bpValid(bpValid), .bpBytes(bpBytes),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn),
    .hostRdData(hostRdData), .totalOut(totalOut)
  );

  task automatic compare(string req);
    total++;
    if (totalOut !== 32'(mTotal)) begin
      bad++;
      $display("FAIL %s totalOut actual=%0d expected=%0d", req, totalOut, 32'(mTotal));
    end
    total++;
    if (hostRdData !== 32'(mRd)) begin
      bad++;
      $display("FAIL %s hostRdData actual=%0d expected=%0d", req, hostRdData, 32'(mRd));
    end
  endtask

  // Apply current inputs for one clock, update model, compare after the edge
  task automatic step(string req);
    longint inc;
    longint bpNow;
    bpNow = (bpValid && fcEnable) ? longint'(bpBytes) : 0;
    if (hostRdEn) mRd = mTotal;
    if (hostWrEn) begin
      mTotal = hostWrData;
    end else if (frameDone) begin
      inc = longint'(frameBytes) + mAcc + bpNow;
      if (inc > 65535) inc = 65535;
      mTotal = (mTotal + inc) % 64'h1_0000_0000;
    end
    if (frameDone || !fcEnable) mAcc = 0;
    else if (bpNow != 0) mAcc = (mAcc + bpNow > 65535) ? 65535 : mAcc + bpNow;
    @(posedge clk);
    @(negedge clk);
    frameDone = 0; bpValid = 0; hostWrEn = 0; hostRdEn = 0;
    compare(req);
  endtask

  task automatic frame(input int n, string req);
    frameDone = 1; frameBytes = 16'(n);
    step(req);
  endtask

  task automatic bp(input int n, string req);
    bpValid = 1; bpBytes = 8'(n);
    step(req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    compare("R1");
    step("R1");

    // R2: flow control off, back-pressure ignored
    frame(64, "R2");
    bp(200, "R2");
    bp(100, "R2");
    frame(1518, "R2");
    step("R2");
    bpValid = 1; bpBytes = 8'd50; frame(10, "R2");

    // R3: banked bytes join next frame, then clear
    fcEnable = 1;
    bp(8, "R3");
    bp(16, "R3");
    step("R3");
    frame(100, "R3");
    frame(100, "R3");

    // R4: same-cycle event merges into the frame
    bp(7, "R4");
    bpValid = 1; bpBytes = 8'd9; frame(20, "R4");

    // R5: cap on one increment
    bp(255, "R5");
    frame(65535, "R5");
    bpValid = 1; bpBytes = 8'd1; frame(65535, "R5");
    frame(65000, "R5");

    // R6: saturation of the bank
    for (int i = 0; i < 300; i++) bp(255, "R6");
    frame(0, "R6");
    frame(100, "R6");

    // R10: mode off drops banked bytes
    bp(40, "R10");
    fcEnable = 0;
    step("R10");
    fcEnable = 1;
    frame(5, "R10");

    // R8: host write, and write against a frame
    hostWrEn = 1; hostWrData = 32'h1234_5678; step("R8");
    bp(30, "R8");
    hostWrEn = 1; hostWrData = 32'd1000; bpValid = 1; bpBytes = 8'd3;
    frame(500, "R8");
    frame(10, "R8");

    // R7: wrap
    hostWrEn = 1; hostWrData = 32'hFFFF_FFF0; step("R7");
    frame(40, "R7");
    frame(65535, "R7");

    // R9: read capture and hold
    hostRdEn = 1; frame(77, "R9");
    step("R9");
    frame(3, "R9");
    hostRdEn = 1; step("R9");
    step("R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule